// File: doc/BRIEF.md
# CAN Transmit Frame Staging Queue

This block is the host-facing transmit path of a CAN controller. Software builds a frame with up to four 32-bit register writes: an identifier word, a length word, and two data words. The block keeps each word in a staging register. When the last word the frame needs arrives, it copies the whole frame into a queue that holds complete frames. Which write completes a frame depends on the staged identifier. A remote-request frame carries no data, so it completes on the length write. A data frame completes on the second data word write.

The protocol engine reads the oldest queued frame from the head outputs and removes it with a one-cycle pop pulse. Full and empty flags tell both sides how far the queue is filled. A completed frame that finds the queue full is discarded, and a sticky overflow flag records the loss until reset.

Top module: `cantx_frame_queue`

## Requirements
- R1: After reset the queue is empty (`txEmpty`=1), `txFull`=0 and `txOverflow`=0.
- R2: A standard data frame (ID word bit 19 = 0, bit 20 = 0) is queued by a write to offset 0x3C (data word 2). A write to offset 0x34 (length word) does not queue it.
- R3: A standard remote frame (ID word bit 19 = 0, bit 20 = 1) is queued by the write to offset 0x34. Writes to offsets 0x38 and 0x3C do not queue it.
- R4: An extended frame (ID word bit 19 = 1) is remote when ID word bit 0 = 1 and is then queued on the 0x34 write. When bit 0 = 0 it is a data frame and is queued on the 0x3C write. Bit 20 plays no part in this decision.
- R5: A queued frame carries the currently staged ID (offset 0x30), length code, data word 1 (offset 0x38) and data word 2. The word written in the completing cycle is already included. Staged values persist after a frame is queued, so repeating only the completing write queues another frame with the same other fields.
- R6: Frames leave in the order they were queued. A pop pulse advances the head by one frame. `txEmpty` rises in the cycle after the last frame is popped.
- R7: `txFull` is 1 while DEPTH frames are held. A completing write while the queue is full is dropped, leaves the queued frames unchanged, and sets `txOverflow`. `txOverflow` stays set until reset.
- R8: A pop pulse while the queue is empty has no effect.
- R9: A write to any offset other than 0x30, 0x34, 0x38 or 0x3C changes no staged value and queues nothing.
- R10: The length code is taken from bits [31:28] of the 0x34 write. All other bits of that word are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register byte offset |
| wrData | input | 32 | Register write data |
| popEn | input | 1 | Remove the head frame (one-cycle pulse) |
| txEmpty | output | 1 | Queue holds no frame |
| txFull | output | 1 | Queue holds DEPTH frames |
| txOverflow | output | 1 | Sticky: a completed frame was dropped |
| headId | output | 32 | ID word of the oldest frame |
| headDlc | output | 4 | Length code of the oldest frame |
| headDw1 | output | 32 | Data word 1 of the oldest frame |
| headDw2 | output | 32 | Data word 2 of the oldest frame |

## Verification
The bench builds the block with DEPTH = 3. This is not a power of two, so the explicit pointer-wrap variant is used. Only three frames are needed to reach the full queue, the dropped-commit path and the sticky overflow. The short depth also lets the random phase wrap both pointers many times. During that phase completions, pops and simultaneous push-and-pop cycles hit the boundaries between full and empty often.

// File: rtl/cantx_pkg.sv
package cantx_pkg;
  localparam int unsigned OFF_ID  = 32'h30;
  localparam int unsigned OFF_DLC = 32'h34;
  localparam int unsigned OFF_DW1 = 32'h38;
  localparam int unsigned OFF_DW2 = 32'h3C;

  typedef struct packed {
    logic [31:0] id;
    logic [3:0]  dlc;
    logic [31:0] dw1;
    logic [31:0] dw2;
  } txFrame_t;

  typedef struct packed {
    logic loadId;
    logic loadDlc;
    logic loadDw1;
    logic loadDw2;
    logic push;
    logic pop;
  } stageCtl_t;
endpackage

// File: rtl/cantx_store.sv
module cantx_store
  import cantx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  stageCtl_t        ctl,
  input  logic [31:0]      wrData,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  output logic             isRemote,
  output txFrame_t         headFrame
);
  logic [31:0] stId, stDw1, stDw2;
  logic [3:0]  stDlc;
  txFrame_t    commitFrame;
  txFrame_t    slots [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stId  <= '0;
      stDlc <= '0;
      stDw1 <= '0;
      stDw2 <= '0;
    end else begin
      if (ctl.loadId)  stId  <= wrData;
      if (ctl.loadDlc) stDlc <= wrData[31:28];
      if (ctl.loadDw1) stDw1 <= wrData;
      if (ctl.loadDw2) stDw2 <= wrData;
    end
  end

  // extended: remote request bit 0; standard: substitute bit 20
  assign isRemote = stId[19] ? stId[0] : stId[20];

  always_comb begin
    commitFrame.id  = stId;
    commitFrame.dlc = ctl.loadDlc ? wrData[31:28] : stDlc;
    commitFrame.dw1 = ctl.loadDw1 ? wrData : stDw1;
    commitFrame.dw2 = ctl.loadDw2 ? wrData : stDw2;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) slots[i] <= '0;
      else if (ctl.push && wrPtr == PTR_W'(i)) slots[i] <= commitFrame;
    end
  end

  assign headFrame = slots[rdPtr];

  // R9: staged ID only moves on its own strobe
  a_r9_stage_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadId |=> $stable(stId));
endmodule

// File: rtl/cantx_ctrl.sv
module cantx_ctrl
  import cantx_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              popEn,
  input  logic              isRemote,
  output stageCtl_t         ctl,
  output logic [PTR_W-1:0]  wrPtr,
  output logic [PTR_W-1:0]  rdPtr,
  output logic              full,
  output logic              empty,
  output logic              overflow
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam bit POW2  = (DEPTH == (1 << PTR_W));

  logic [CNT_W-1:0] count;
  logic hitId, hitDlc, hitDw1, hitDw2, commitReq;
  logic [PTR_W-1:0] wrNext, rdNext;

  assign hitId  = wrEn && (wrAddr == ADDR_W'(OFF_ID));
  assign hitDlc = wrEn && (wrAddr == ADDR_W'(OFF_DLC));
  assign hitDw1 = wrEn && (wrAddr == ADDR_W'(OFF_DW1));
  assign hitDw2 = wrEn && (wrAddr == ADDR_W'(OFF_DW2));

  assign commitReq = (hitDlc && isRemote) || (hitDw2 && !isRemote);

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  always_comb begin
    ctl.loadId  = hitId;
    ctl.loadDlc = hitDlc;
    ctl.loadDw1 = hitDw1;
    ctl.loadDw2 = hitDw2;
    ctl.push    = commitReq && !full;
    ctl.pop     = popEn && !empty;
  end

  if (POW2) begin : g_wrapNatural
    assign wrNext = wrPtr + 1'b1;
    assign rdNext = rdPtr + 1'b1;
  end else begin : g_wrapCompare
    assign wrNext = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
    assign rdNext = (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
      overflow <= 1'b0;
    end else begin
      if (ctl.push) wrPtr <= wrNext;
      if (ctl.pop)  rdPtr <= rdNext;
      case ({ctl.push, ctl.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (commitReq && full) overflow <= 1'b1;
    end
  end

  // R1: flags never both set
  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));
  // R3: remote frame completes on the length write
  a_r3_remote_dlc_commit: assert property (@(posedge clk) disable iff (!rstN)
    (hitDlc && isRemote && !full) |-> ctl.push);
  // R2: data frame is not queued by the length write
  a_r2_data_dlc_no_commit: assert property (@(posedge clk) disable iff (!rstN)
    (hitDlc && !isRemote) |-> !ctl.push);
  // R6: last pop empties the queue
  a_r6_empty_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_W'(1) && ctl.pop && !ctl.push) |=> empty);
  // R7: overflow is sticky
  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  // R7: full queue stays full without a pop
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (full && !popEn) |=> full);
endmodule

// File: rtl/cantx_frame_queue.sv
module cantx_frame_queue
  import cantx_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              popEn,
  output logic              txEmpty,
  output logic              txFull,
  output logic              txOverflow,
  output logic [31:0]       headId,
  output logic [3:0]        headDlc,
  output logic [31:0]       headDw1,
  output logic [31:0]       headDw2
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  stageCtl_t        ctl;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             isRemote;
  txFrame_t         headFrame;

  cantx_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .popEn(popEn),
    .isRemote(isRemote), .ctl(ctl), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .full(txFull), .empty(txEmpty), .overflow(txOverflow)
  );

  cantx_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData), .wrPtr(wrPtr),
    .rdPtr(rdPtr), .isRemote(isRemote), .headFrame(headFrame)
  );

  assign headId  = headFrame.id;
  assign headDlc = headFrame.dlc;
  assign headDw1 = headFrame.dw1;
  assign headDw2 = headFrame.dw2;
endmodule

// File: tb/sim_cantx_frame_queue.sv
module sim_cantx_frame_queue;
  localparam int DEPTH = 3;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rstN;
  logic wrEn;
  logic [ADDR_W-1:0] wrAddr;
  logic [31:0] wrData;
  logic popEn;
  logic txEmpty, txFull, txOverflow;
  logic [31:0] headId, headDw1, headDw2;
  logic [3:0] headDlc;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [31:0] sId, sDw1, sDw2;
  logic [3:0]  sDlc;
  logic [31:0] qId [DEPTH];
  logic [3:0]  qDlc[DEPTH];
  logic [31:0] qDw1[DEPTH];
  logic [31:0] qDw2[DEPTH];
  int mCount;
  bit mOvf;

  always #2 clk = ~clk;

  cantx_frame_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .popEn(popEn), .txEmpty(txEmpty), .txFull(txFull), .txOverflow(txOverflow),
    .headId(headId), .headDlc(headDlc), .headDw1(headDw1), .headDw2(headDw2)
  );

  function automatic bit remoteOf(logic [31:0] id);
    if (id[19]) return id[0];
    return id[20];
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compareAll(string req);
    check(req, "empty", 32'(txEmpty), 32'(mCount == 0));
    check(req, "full", 32'(txFull), 32'(mCount == DEPTH));
    check(req, "overflow", 32'(txOverflow), 32'(mOvf));
    if (mCount > 0) begin
      check(req, "headId", headId, qId[0]);
      check(req, "headDlc", 32'(headDlc), 32'(qDlc[0]));
      check(req, "headDw1", headDw1, qDw1[0]);
      check(req, "headDw2", headDw2, qDw2[0]);
    end
  endtask

  task automatic step(bit we, logic [7:0] a, logic [31:0] d, bit p, string req);
    bit commit, wasFull;
    logic [31:0] fId, fDw1, fDw2;
    logic [3:0] fDlc;
    wrEn = we; wrAddr = a; wrData = d; popEn = p;
    @(posedge clk);
    commit = we && ((a == 8'h34 && remoteOf(sId)) || (a == 8'h3C && !remoteOf(sId)));
    fId = sId;
    fDlc = (we && a == 8'h34) ? d[31:28] : sDlc;
    fDw1 = (we && a == 8'h38) ? d : sDw1;
    fDw2 = (we && a == 8'h3C) ? d : sDw2;
    wasFull = (mCount == DEPTH);
    if (we) begin
      if (a == 8'h30) sId = d;
      if (a == 8'h34) sDlc = d[31:28];
      if (a == 8'h38) sDw1 = d;
      if (a == 8'h3C) sDw2 = d;
    end
    if (p && mCount > 0) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        qId[i] = qId[i+1]; qDlc[i] = qDlc[i+1];
        qDw1[i] = qDw1[i+1]; qDw2[i] = qDw2[i+1];
      end
      mCount--;
    end
    if (commit) begin
      if (wasFull) mOvf = 1'b1;
      else begin
        qId[mCount] = fId; qDlc[mCount] = fDlc;
        qDw1[mCount] = fDw1; qDw2[mCount] = fDw2;
        mCount++;
      end
    end
    @(negedge clk);
    wrEn = 1'b0; popEn = 1'b0;
    compareAll(req);
  endtask

  task automatic doReset();
    rstN = 1'b0; wrEn = 1'b0; popEn = 1'b0; wrAddr = '0; wrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    sId = '0; sDlc = '0; sDw1 = '0; sDw2 = '0; mCount = 0; mOvf = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    doReset();
    compareAll("R1");

    // R2 standard data frame: length write alone does not queue
    step(1, 8'h30, 32'h2460_0000, 0, "R2");
    step(1, 8'h34, 32'h8FFF_FFFF, 0, "R10");
    check("R2", "noCommitOnDlc", 32'(txEmpty), 32'd1);
    step(1, 8'h38, 32'hDEAD_BEEF, 0, "R2");
    step(1, 8'h3C, 32'h0102_0304, 0, "R2");
    check("R2", "queuedOnDw2", 32'(txEmpty), 32'd0);
    check("R10", "dlcField", 32'(headDlc), 32'h8);
    // R5 staged values persist: repeat only the completing write
    step(1, 8'h3C, 32'hAAAA_5555, 0, "R5");
    // R9 stray offsets change nothing
    step(1, 8'h40, 32'hFFFF_FFFF, 0, "R9");
    step(1, 8'h2C, 32'hFFFF_FFFF, 0, "R9");
    check("R9", "noCommitStray", 32'(mCount), 32'd2);
    // R6 pop oldest
    step(0, 8'h00, 0, 1, "R6");
    step(0, 8'h00, 0, 1, "R6");
    check("R6", "emptyAfterLast", 32'(txEmpty), 32'd1);
    step(0, 8'h00, 0, 1, "R8");
    check("R8", "popEmptyIgnored", 32'(txEmpty), 32'd1);

    // R3 standard remote
    step(1, 8'h30, 32'h0010_0000, 0, "R3");
    step(1, 8'h38, 32'h1111_1111, 0, "R3");
    step(1, 8'h3C, 32'h2222_2222, 0, "R3");
    check("R3", "noCommitOnData", 32'(txEmpty), 32'd1);
    step(1, 8'h34, 32'h3000_0000, 1, "R3");
    check("R3", "queuedOnDlc", 32'(txEmpty), 32'd0);
    step(0, 8'h00, 0, 1, "R3");

    // R4 extended remote / data, bit 20 irrelevant
    step(1, 8'h30, 32'h0008_0001, 0, "R4");
    step(1, 8'h34, 32'h1000_0000, 0, "R4");
    check("R4", "extRemoteOnDlc", 32'(mCount), 32'd1);
    step(1, 8'h30, 32'h0018_0ABC, 0, "R4");
    step(1, 8'h34, 32'h2000_0000, 0, "R4");
    check("R4", "extDataNotOnDlc", 32'(mCount), 32'd1);
    step(1, 8'h3C, 32'h7777_0000, 0, "R4");
    check("R4", "extDataOnDw2", 32'(mCount), 32'd2);

    // R7 fill, overflow, sticky
    step(1, 8'h3C, 32'h8888_0000, 0, "R7");
    check("R7", "fullFlag", 32'(txFull), 32'd1);
    step(1, 8'h3C, 32'h9999_0000, 0, "R7");
    check("R7", "overflowSet", 32'(txOverflow), 32'd1);
    step(0, 8'h00, 0, 1, "R7");
    check("R7", "overflowSticky", 32'(txOverflow), 32'd1);

    // random phase
    doReset();
    compareAll("R1");
    for (int n = 0; n < 600; n++) begin
      int sel;
      logic [7:0] a;
      logic [31:0] d;
      sel = int'($urandom % 6);
      case (sel)
        0: a = 8'h30; 1: a = 8'h34; 2: a = 8'h38; 3, 4: a = 8'h3C;
        default: a = 8'h44;
      endcase
      d = $urandom;
      step(($urandom % 4) != 0, a, d, ($urandom % 3) == 0, "R6");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule